// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Sequencer

This block is the clocked front end of a small burst SRAM. It works on the rising edge of one clock. On each edge it looks at the address, the write data, three chip enables, two address strobes, an advance input and the write enables. From these it decides whether this cycle is a read, a write or a deselect. A strobe loads a start address. A 2-bit counter then walks the two low address bits, in linear or interleaved order, so that a burst of four words needs only one address transfer. If the advance input is held high, the burst waits and the same word is accessed again.

The controller keeps a three-state machine. `ST_OFF` is the deselected or powered-down state. `ST_RD` means a read was registered in the last cycle, and `ST_WR` means a write was registered. The state changes as follows:
- A valid processor strobe goes to `ST_RD`.
- A processor strobe with a failed secondary enable goes to `ST_OFF`.
- A valid controller strobe goes to `ST_WR` or `ST_RD`, depending on the write enables.
- A controller strobe with any enable inactive goes to `ST_OFF`.
- With no strobe, `ST_RD` and `ST_WR` continue the burst and pick RD or WR from the write enables, while `ST_OFF` stays in `ST_OFF`.

The registered access is retired on the next edge. A write updates the array. A read loads the output register and raises the output enable. Any other state drops the output enable, which gives a single-cycle deselect.

Top module: `sbs_ctrl`

## Requirements
- R1: After reset the state is ST_OFF and `dout_oe` is 0. Cycles with no strobe keep it deselected.
- R2: When `sp_n`=0, `ce_n`=0, `ce2`=1 and `ce3_n`=0 on an edge, a read is registered at `addr`. This holds whatever `gw_n`, `bwe_n`, `be_n` and `sc_n` are, so the processor strobe wins over the controller strobe.
- R3: While `ce_n`=1, `sp_n` has no effect. Inside a burst with `sc_n`=1, the burst keeps going as if `sp_n` were 1.
- R4: When `sp_n`=0 and `ce_n`=0, but `ce2`=0 or `ce3_n`=1, the block enters ST_OFF.
- R5: When `sc_n`=0 (and there is no valid processor strobe) with `ce_n`=0, `ce2`=1 and `ce3_n`=0, a read or write is registered at `addr`. The write data is taken on the same edge.
- R6: When `sc_n`=0 (and there is no valid processor strobe) while `ce_n`=1, `ce2`=0 or `ce3_n`=1, the block enters ST_OFF.
- R7: With `mode`=0 (linear), the low two address bits of the burst access are (start + count) mod 4.
- R8: With `mode`=1 (interleaved), the low two address bits are start XOR count.
- R9: In a burst, `adv_n`=0 steps the 2-bit count, which wraps after four steps. `adv_n`=1 re-accesses the same address as a wait state.
- R10: The write lane mask is decided as follows:
  - `gw_n`=0 writes all four bytes.
  - Otherwise `bwe_n`=0 writes byte lane i (bits 8i+7..8i) wherever `be_n[i]`=0.
  - An empty mask makes the cycle a read.
- R11: A read registered on edge k drives the word on `dout` with `dout_oe`=1 after edge k+1. A registered write leaves `dout_oe` at 0.
- R12: `dout_oe` falls exactly one edge after ST_OFF is registered and stays 0 while deselected.
- R13: After a processor-strobe read, a next cycle with `adv_n`=1 and write enables active writes to that same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, 4 byte lanes |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| sp_n | input | 1 | Processor address strobe, active low |
| sc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | 4 | Per-lane byte selects, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| dout | output | 32 | Read data register |
| dout_oe | output | 1 | Output drive enable (0 = high impedance) |

## Verification
The hardest case to reach is a wrap-around burst that has wait states mixed into it. In that case, the counter has to hold during the wait cycles, wrap past four, and still produce the same word order in both burst modes. The bench first fills the array with writes started by the controller strobe. It then sweeps every start offset under both orders. For each one it writes a four-beat burst, reads it back for eight beats with `adv_n` low, and also runs an irregular pattern of `adv_n` high and low. A cycle-accurate reference array checks every output edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RD  = 2'd1,
        ST_WR  = 2'd2
    } st_t;

    // Low address bits for burst beat cnt from start bits base.
    function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction
endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          mode,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr
);
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nx;

    always_comb begin
        cnt_nx   = step ? cnt_q + 2'd1 : cnt_q;
        cur_addr = load ? addr_in
                        : {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_nx, mode)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (load) begin
            base_q <= addr_in;
            cnt_q  <= 2'd0;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end

    // R9: counter advances by one (mod 4) on a step, holds otherwise
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  st_t             st,
    input  logic [AW-1:0]   addr,
    input  logic [NB*8-1:0] wdata,
    input  logic [NB-1:0]   mask,
    output logic [NB*8-1:0] dout,
    output logic            dout_oe
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * 8;

    logic [DW-1:0] mem [DEPTH];

    // Self-timed write: retire the registered write on the next edge.
    always_ff @(posedge clk) begin
        if (st == ST_WR) begin
            for (int l = 0; l < NB; l++) begin
                if (mask[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end

    // Output pipeline register; drive only after a registered read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= (st == ST_RD);
            if (st == ST_RD) dout <= mem[addr];
        end
    end

    // R11: a write stage never enables the output on the next edge
    a_r11_wr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR) |=> !dout_oe);
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    localparam int DW = NB * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ce_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          sp_n,
    input  logic          sc_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] be_n,
    input  logic          mode,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    st_t           st_q, st_nx;
    logic          load, step, chips_ok, sp_go;
    logic [NB-1:0] mask_in, mask_q;
    logic [AW-1:0] cur_addr, addr_q;
    logic [DW-1:0] wdata_q;

    sbs_burst_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .mode(mode), .addr_in(addr), .cur_addr(cur_addr)
    );

    // Next-state decode
    always_comb begin
        mask_in  = !gw_n ? '1 : (!bwe_n ? ~be_n : '0);
        chips_ok = ce2 && !ce3_n;
        sp_go    = !sp_n && !ce_n;
        load     = 1'b0;
        step     = 1'b0;
        st_nx    = st_q;
        if (sp_go) begin
            load  = chips_ok;
            st_nx = chips_ok ? ST_RD : ST_OFF;
        end else if (!sc_n) begin
            load  = !ce_n && chips_ok;
            st_nx = !load ? ST_OFF : ((|mask_in) ? ST_WR : ST_RD);
        end else begin
            unique case (st_q)
                ST_OFF: st_nx = ST_OFF;
                ST_RD, ST_WR: begin
                    step  = !adv_n;
                    st_nx = (|mask_in) ? ST_WR : ST_RD;
                end
                default: st_nx = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nx;
    end

    // Access stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (st_nx != ST_OFF) begin
            addr_q  <= cur_addr;
            wdata_q <= wdata;
            mask_q  <= mask_in;
        end
    end

    sbs_array #(.AW(AW), .NB(NB)) u_array (
        .clk(clk), .rst_n(rst_n), .st(st_q), .addr(addr_q),
        .wdata(wdata_q), .mask(mask_q), .dout(dout), .dout_oe(dout_oe)
    );

    // R2: a valid processor strobe always registers a read at the pin address
    a_r2_sp_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_n && !ce_n && ce2 && !ce3_n) |=>
            (st_q == ST_RD && addr_q == $past(addr)));
    // R4: processor strobe with failed secondary enables deselects
    a_r4_sp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_n && !ce_n && (!ce2 || ce3_n)) |=> (st_q == ST_OFF));
    // R6: controller strobe with primary enable high powers down
    a_r6_sc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_n && ce_n) |=> (st_q == ST_OFF));
    // R9: a wait state keeps the access address
    a_r9_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF && sp_n && sc_n && adv_n) |=> (addr_q == $past(addr_q)));
    // R10: a valid controller strobe with global write registers a write
    a_r10_gw: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_n && !sc_n && !ce_n && ce2 && !ce3_n && !gw_n) |=> (st_q == ST_WR));
    // R12: output drive follows only a registered read, and drops after ST_OFF
    a_r12_oe_src: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ($past(st_q) == ST_RD));
    a_r12_off: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |=> !dout_oe);
endmodule

// File: tb/sbs_ctrl_bench.sv
module sbs_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int K_OFF = 0, K_RD = 1, K_WR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          ce_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic          sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic          mode = 1'b0;
    logic [31:0]   dout;
    logic          dout_oe;

    int checks = 0, errors = 0, seed = 1;
    bit done = 0;

    // reference model
    logic [31:0]   rmem [64];
    int            s_kind = K_OFF;
    logic [AW-1:0] s_addr = '0, m_base = '0;
    logic [31:0]   s_data = '0, e_dout = '0;
    logic [3:0]    s_mask = '0;
    logic [1:0]    m_cnt = '0;
    logic          e_oe = 1'b0;

    sbs_ctrl #(.AW(AW), .NB(4)) u_sbs_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n), .sp_n(sp_n), .sc_n(sc_n),
        .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n),
        .mode(mode), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] next_data();
        seed = seed + 1;
        return 32'h9E3779B9 * seed ^ 32'h5A0F00C3;
    endfunction

    task automatic model_step();
        logic [3:0] m;
        if (s_kind == K_RD) begin e_oe = 1'b1; e_dout = rmem[s_addr]; end
        else e_oe = 1'b0;
        if (s_kind == K_WR)
            for (int l = 0; l < 4; l++)
                if (s_mask[l]) rmem[s_addr][l*8 +: 8] = s_data[l*8 +: 8];
        m = !gw_n ? 4'hF : (!bwe_n ? ~be_n : 4'h0);
        s_data = wdata; s_mask = m;
        if (!sp_n && !ce_n) begin
            if (ce2 && !ce3_n) begin
                m_base = addr; m_cnt = 0; s_addr = addr; s_kind = K_RD;
            end else s_kind = K_OFF;
        end else if (!sc_n) begin
            if (ce_n || !ce2 || ce3_n) s_kind = K_OFF;
            else begin
                m_base = addr; m_cnt = 0; s_addr = addr;
                s_kind = (m != 0) ? K_WR : K_RD;
            end
        end else if (s_kind != K_OFF) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            s_addr = {m_base[AW-1:2],
                      mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            s_kind = (m != 0) ? K_WR : K_RD;
        end
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (dout_oe !== e_oe) begin
            errors++;
            $display("FAIL %s dout_oe got %0b exp %0b", tag, dout_oe, e_oe);
        end
        if (e_oe) begin
            checks++;
            if (dout !== e_dout) begin
                errors++;
                $display("FAIL %s dout got %h exp %h", tag, dout, e_dout);
            end
        end
    endtask

    task automatic cyc(input logic [AW-1:0] a, input logic [31:0] d,
                       input logic cen, input logic c2, input logic c3n,
                       input logic spn, input logic scn, input logic advn,
                       input logic gwn, input logic bwen, input logic [3:0] ben,
                       input string tag);
        addr = a; wdata = d; ce_n = cen; ce2 = c2; ce3_n = c3n;
        sp_n = spn; sc_n = scn; adv_n = advn; gw_n = gwn; bwe_n = bwen; be_n = ben;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic sc_wr(input logic [AW-1:0] a, input string tag);
        cyc(a, next_data(), 0, 1, 0, 1, 0, 1, 0, 1, 4'hF, tag);
    endtask
    task automatic sc_rd(input logic [AW-1:0] a, input string tag);
        cyc(a, 32'h0, 0, 1, 0, 1, 0, 1, 1, 1, 4'hF, tag);
    endtask
    task automatic sp_rd(input logic [AW-1:0] a, input string tag);
        cyc(a, 32'h0, 0, 1, 0, 0, 1, 1, 1, 1, 4'hF, tag);
    endtask
    task automatic cont(input logic advn, input logic wr, input string tag);
        cyc('0, next_data(), 0, 1, 0, 1, 1, advn, !wr, 1, 4'hF, tag);
    endtask
    task automatic desel(input string tag);
        cyc('0, 32'h0, 1, 1, 0, 1, 0, 1, 1, 1, 4'hF, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1");                       // reset: output not driven
        rst_n = 1'b1;
        cyc('0, 32'h0, 1, 1, 0, 1, 1, 1, 1, 1, 4'hF, "R1");
        cyc('0, 32'h0, 0, 1, 0, 1, 1, 0, 0, 1, 4'hF, "R1"); // no strobe stays off

        for (int i = 0; i < 64; i++) sc_wr(6'(i), "R5");
        for (int i = 0; i < 64; i += 7) sc_rd(6'(i), "R11");
        desel("R12");
        desel("R12");

        // R7 / R8: both orders, every start offset, with wrap
        for (int m = 0; m < 2; m++) begin
            desel("R6");
            mode = 1'(m);
            for (int s = 0; s < 4; s++) begin
                sc_wr(6'(16 + 8*m + s), m ? "R8" : "R7");
                for (int b = 0; b < 3; b++) cont(0, 1, m ? "R8" : "R7");
                sp_rd(6'(16 + 8*m + s), m ? "R8" : "R7");
                for (int b = 0; b < 7; b++) cont(0, 0, m ? "R8" : "R7");
                // R9: irregular wait states
                sp_rd(6'(16 + 8*m + s), "R9");
                for (int b = 0; b < 9; b++) cont(logic'(b % 3 == 1), 0, "R9");
                desel("R12");
                cont(0, 0, "R12");             // stays deselected
            end
        end
        mode = 1'b0;

        // R10: byte lanes
        cyc(6'd8, 32'hDEADBEEF, 0, 1, 0, 1, 0, 1, 1, 0, 4'b1010, "R10");
        sc_rd(6'd8, "R10");
        cyc(6'd9, 32'hCAFEF00D, 0, 1, 0, 1, 0, 1, 1, 0, 4'b0111, "R10");
        sc_rd(6'd9, "R10");
        cyc(6'd10, 32'h12345678, 0, 1, 0, 1, 0, 1, 1, 1, 4'h0, "R10"); // be without bwe: read
        sc_rd(6'd10, "R10");
        cont(1, 0, "R11");

        // R2 / R13: processor read ignoring write enables, then write same address
        cyc(6'd33, 32'h0BADF00D, 0, 1, 0, 0, 0, 1, 0, 0, 4'h0, "R2");
        cyc(6'd0, 32'h600DCAFE, 0, 1, 0, 1, 1, 1, 0, 1, 4'hF, "R13");
        sc_rd(6'd33, "R13");
        cont(1, 0, "R13");

        // R3: processor strobe ignored with primary enable high
        sp_rd(6'd44, "R3");
        cyc(6'd3, 32'h0, 1, 1, 0, 0, 1, 0, 1, 1, 4'hF, "R3");
        cyc(6'd3, 32'h0, 1, 1, 0, 0, 1, 0, 1, 1, 4'hF, "R3");
        cont(0, 0, "R3");
        // R6: controller strobe with enable high deselects
        cyc(6'd3, 32'h0, 1, 1, 0, 0, 0, 1, 1, 1, 4'hF, "R6");
        cont(0, 0, "R6");
        // R6: controller strobe with ce2 low
        sc_rd(6'd5, "R6");
        cyc(6'd5, 32'h0, 0, 0, 0, 1, 0, 1, 1, 1, 4'hF, "R6");
        cont(0, 0, "R6");
        // R4: processor strobe with failed secondary enables
        sp_rd(6'd12, "R4");
        cyc(6'd12, 32'h0, 0, 0, 0, 0, 1, 1, 1, 1, 4'hF, "R4");
        cont(0, 0, "R4");
        sp_rd(6'd13, "R4");
        cyc(6'd13, 32'h0, 0, 1, 1, 0, 1, 1, 1, 1, 4'hF, "R4");
        cont(0, 0, "R4");
        desel("R12");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule